// File: doc/BRIEF.md
# Line-Locked Video Output Timing Generator

This block produces the line and field timing for a digital video output bus. The bus carries an 8-bit luma byte and an 8-bit colour-difference byte per sample, one sample per cycle of the half line-locked clock. A sample counter and a line counter follow the raster of the selected field rate. The line lengths, active widths and frame heights are parameters. From the two counts the block decodes a horizontal reference window that marks valid data, a horizontal sync pulse whose rising sample is set by an input, a vertical sync pulse, and an odd-field flag.

In the same cycle the block puts the colour-difference samples onto the UV lane, in either the 4:2:2 or the 4:1:1 layout. Outside the active window it drives blanking levels on both lanes. The bus is not tri-stated inside the block. A pad enable goes to the pad ring, and a fast-enable pin can turn it off. Any of three multiplexer mode bits overrides that pin and keeps the bus driven. The mode, format and sync position inputs are static. Change them only while reset is held.

Top module: `yuv_timing_gen`

## Requirements
- R1: A line lasts LINE_60 samples (default 780) when mode_50_i is 0 and LINE_50 samples (default 944) when it is 1, so consecutive rising edges of href_o are exactly one line apart.
- R2: href_o is high for ACT_60 samples (default 640) in 60 Hz mode and ACT_50 samples (default 768) in 50 Hz mode. It rises at sample index HREF_START of every line, where index 0 is the first sample of the line.
- R3: href_o keeps its per-line window during the lines in which vs_o is high.
- R4: A frame has LINES_60 (525) or LINES_50 (625) lines. The second field starts at the middle sample of line (lines-1)/2, which is half a frame after the first field. odd_o is 1 from the start of the first field up to that point and 0 for the rest of the frame.
- R5: vs_o is high for VS_LINES lines (default 6), counted from the first sample of each field, and low at all other times.
- R6: hs_o rises at sample index hs_pos_i and stays high for HS_WIDTH samples, or until the end of the line if that comes first.
- R7: When fmt_411_i is 0, uv_o carries u_i on even offsets from the href_o rising sample and v_i on odd offsets, so the first active sample is U.
- R8: When fmt_411_i is 1, for offset k = (offset mod 4), uv_o[7:6] is u_i[7-2k:6-2k], uv_o[5:4] is v_i[7-2k:6-2k] and uv_o[3:0] is 0.
- R9: While href_o is 0, y_o is 8'h10 and uv_o is 8'h80. While href_o is 1, y_o equals y_i.
- R10: bus_oe_o is 0 only when fast_en_i is 1 and all bits of mux_force_i are 0. Otherwise it is 1.
- R11: While rst_ni is low, both counters sit at zero: href_o is 0, vs_o is 1 and odd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half line-locked sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_50_i | input | 1 | 1 selects the 50 Hz raster, 0 selects the 60 Hz raster |
| fmt_411_i | input | 1 | 1 selects the 4:1:1 UV layout, 0 selects 4:2:2 |
| hs_pos_i | input | SW (10) | Sample index of the rising edge of hs_o |
| fast_en_i | input | 1 | 1 requests that the output bus be released |
| mux_force_i | input | 3 | Multiplexer mode bits; any 1 keeps the bus driven |
| y_i | input | 8 | Luma sample from the decoder |
| u_i | input | 8 | Blue colour-difference sample |
| v_i | input | 8 | Red colour-difference sample |
| y_o | output | 8 | Luma bus lane |
| uv_o | output | 8 | Multiplexed colour-difference bus lane |
| bus_oe_o | output | 1 | Pad enable for y_o and uv_o |
| href_o | output | 1 | Active-data window |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| odd_o | output | 1 | Odd-field flag |

## Verification
The bench builds the block with a shrunken raster. Lines are 20 or 24 samples long, with 12 or 16 active. Frames are 11 or 13 lines, the vertical pulse is 2 lines wide and the sync pulse is 3 samples wide. With these values several whole frames of both rates fit in a short run. The mid-line field boundary, the frame wrap, and the vertical pulse that straddles a line boundary are each crossed many times. The runs place hs_pos_i at zero, in mid-line and two samples before the line end, so all three sync window cases are covered. Both UV layouts are run under changing chroma input while the enable inputs toggle.

// File: rtl/yuv_tg_pkg.sv
package yuv_tg_pkg;
  localparam logic [7:0] Y_BLANK  = 8'h10;
  localparam logic [7:0] UV_BLANK = 8'h80;

  typedef enum logic {
    FMT_422 = 1'b0,
    FMT_411 = 1'b1
  } uv_fmt_e;
endpackage

// File: rtl/yuv_tg_counter.sv
module yuv_tg_counter #(
  parameter int SW = 10,
  parameter int LW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] line_len_i,
  input  logic [LW-1:0] frame_lines_i,
  output logic [SW-1:0] samp_o,
  output logic [LW-1:0] line_o
);
  logic samp_last, line_last;

  assign samp_last = (samp_o == line_len_i - SW'(1));
  assign line_last = (line_o == frame_lines_i - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      line_o <= '0;
    end else if (samp_last) begin
      samp_o <= '0;
      line_o <= line_last ? '0 : line_o + LW'(1);
    end else begin
      samp_o <= samp_o + SW'(1);
    end
  end

  AST_SAMP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o < line_len_i) else $error("sample index past line end"); // R1

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_last && !line_last) |=> (line_o == $past(line_o) + LW'(1) && samp_o == '0))
    else $error("line did not advance"); // R4

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_last && line_last) |=> (line_o == '0))
    else $error("frame did not wrap"); // R4
endmodule

// File: rtl/yuv_tg_sync.sv
module yuv_tg_sync #(
  parameter int SW         = 10,
  parameter int LW         = 10,
  parameter int HREF_START = 64,
  parameter int HS_WIDTH   = 32,
  parameter int VS_LINES   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] samp_i,
  input  logic [LW-1:0] line_i,
  input  logic [SW-1:0] line_len_i,
  input  logic [SW-1:0] act_len_i,
  input  logic [LW-1:0] frame_lines_i,
  input  logic [SW-1:0] hs_pos_i,
  output logic          href_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          odd_o
);
  localparam logic [SW:0] HrefStart = (SW+1)'(HREF_START);
  localparam logic [SW:0] HsWidth   = (SW+1)'(HS_WIDTH);
  localparam logic [LW-1:0] VsLines = LW'(VS_LINES);

  logic [SW:0]   samp_x, href_end, hs_end;
  logic [SW-1:0] half_samp;
  logic [LW-1:0] mid_line, vs2_end;
  logic          vs_f1, vs_f2;

  assign samp_x    = {1'b0, samp_i};
  assign href_end  = HrefStart + {1'b0, act_len_i};
  assign hs_end    = {1'b0, hs_pos_i} + HsWidth;
  assign half_samp = line_len_i >> 1;
  assign mid_line  = frame_lines_i >> 1;
  assign vs2_end   = mid_line + VsLines;

  always_comb begin
    href_o = (samp_x >= HrefStart) && (samp_x < href_end);
    hs_o   = (samp_i >= hs_pos_i) && (samp_x < hs_end);
    vs_f1  = (line_i < VsLines);
    vs_f2  = ((line_i == mid_line) && (samp_i >= half_samp)) ||
             ((line_i > mid_line) && (line_i < vs2_end)) ||
             ((line_i == vs2_end) && (samp_i < half_samp));
    vs_o   = vs_f1 || vs_f2;
    odd_o  = (line_i < mid_line) || ((line_i == mid_line) && (samp_i < half_samp));
  end

  AST_HREF_RISE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(href_o) |-> (samp_x == HrefStart)) else $error("href rose off start"); // R2

  AST_HS_RISE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_o) && $stable(hs_pos_i)) |-> (samp_i == hs_pos_i))
    else $error("hs rose off programmed sample"); // R6

  AST_VS_AT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_o) |-> ((line_i == '0 && samp_i == '0) ||
                     (line_i == mid_line && samp_i == half_samp)))
    else $error("vs rose off field start"); // R5

  AST_ODD_WITH_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(odd_o) || $fell(odd_o)) |-> $rose(vs_o))
    else $error("field flag moved without field start"); // R4
endmodule

// File: rtl/yuv_tg_chroma.sv
module yuv_tg_chroma
  import yuv_tg_pkg::*;
#(
  parameter int SW         = 10,
  parameter int HREF_START = 64
) (
  input  logic          href_i,
  input  uv_fmt_e       fmt_i,
  input  logic [SW-1:0] samp_i,
  input  logic [7:0]    y_i,
  input  logic [7:0]    u_i,
  input  logic [7:0]    v_i,
  output logic [7:0]    y_o,
  output logic [7:0]    uv_o
);
  logic [SW-1:0] offs;
  logic [1:0]    k;
  logic [7:0]    u_sh, v_sh;

  assign offs = samp_i - SW'(HREF_START);
  assign k    = offs[1:0];
  assign u_sh = u_i << {k, 1'b0};
  assign v_sh = v_i << {k, 1'b0};

  always_comb begin
    if (!href_i) begin
      y_o  = Y_BLANK;
      uv_o = UV_BLANK;
    end else begin
      y_o = y_i;
      if (fmt_i == FMT_411) uv_o = {u_sh[7:6], v_sh[7:6], 4'b0000};
      else                  uv_o = offs[0] ? v_i : u_i;
    end
  end
endmodule

// File: rtl/yuv_timing_gen.sv
module yuv_timing_gen
  import yuv_tg_pkg::*;
#(
  parameter int LINE_60    = 780,
  parameter int LINE_50    = 944,
  parameter int ACT_60     = 640,
  parameter int ACT_50     = 768,
  parameter int LINES_60   = 525,
  parameter int LINES_50   = 625,
  parameter int HREF_START = 64,
  parameter int HS_WIDTH   = 32,
  parameter int VS_LINES   = 6,
  localparam int LMAX = (LINE_50 > LINE_60) ? LINE_50 : LINE_60,
  localparam int FMAX = (LINES_50 > LINES_60) ? LINES_50 : LINES_60,
  localparam int SW   = $clog2(LMAX + 1),
  localparam int LW   = $clog2(FMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_50_i,
  input  logic          fmt_411_i,
  input  logic [SW-1:0] hs_pos_i,
  input  logic          fast_en_i,
  input  logic [2:0]    mux_force_i,
  input  logic [7:0]    y_i,
  input  logic [7:0]    u_i,
  input  logic [7:0]    v_i,
  output logic [7:0]    y_o,
  output logic [7:0]    uv_o,
  output logic          bus_oe_o,
  output logic          href_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          odd_o
);
  logic [SW-1:0] line_len, act_len, samp;
  logic [LW-1:0] frame_lines, line;
  uv_fmt_e       fmt;

  assign line_len    = mode_50_i ? SW'(LINE_50)  : SW'(LINE_60);
  assign act_len     = mode_50_i ? SW'(ACT_50)   : SW'(ACT_60);
  assign frame_lines = mode_50_i ? LW'(LINES_50) : LW'(LINES_60);
  assign fmt         = fmt_411_i ? FMT_411 : FMT_422;

  // multiplexer modes override the fast-enable release
  assign bus_oe_o = !fast_en_i || (|mux_force_i);

  yuv_tg_counter #(.SW(SW), .LW(LW)) u_cnt (
    .clk_i, .rst_ni,
    .line_len_i(line_len), .frame_lines_i(frame_lines),
    .samp_o(samp), .line_o(line)
  );

  yuv_tg_sync #(
    .SW(SW), .LW(LW), .HREF_START(HREF_START),
    .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES)
  ) u_sync (
    .clk_i, .rst_ni,
    .samp_i(samp), .line_i(line),
    .line_len_i(line_len), .act_len_i(act_len), .frame_lines_i(frame_lines),
    .hs_pos_i,
    .href_o, .hs_o, .vs_o, .odd_o
  );

  yuv_tg_chroma #(.SW(SW), .HREF_START(HREF_START)) u_chroma (
    .href_i(href_o), .fmt_i(fmt), .samp_i(samp),
    .y_i, .u_i, .v_i,
    .y_o, .uv_o
  );

  AST_OE_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mux_force_i) |-> bus_oe_o) else $error("bus released under mux mode"); // R10

  AST_RESET_HREF: assert property (@(posedge clk_i)
    !rst_ni |-> (!href_o && vs_o && odd_o)) else $error("reset state wrong"); // R11
endmodule

// File: tb/yuv_timing_gen_tb.sv
module yuv_timing_gen_tb;
  localparam int L60 = 20, L50 = 24, A60 = 12, A50 = 16;
  localparam int F60 = 11, F50 = 13, HST = 4, HSW = 3, VSL = 2;
  localparam int SW = $clog2(L50 + 1);

  logic clk = 0, rst_n = 0;
  logic mode_50 = 0, fmt_411 = 0, fast_en = 0;
  logic [SW-1:0] hs_pos = '0;
  logic [2:0] mux_force = '0;
  logic [7:0] y_in = 0, u_in = 0, v_in = 0;
  logic [7:0] y_out, uv_out;
  logic oe, href, hs, vs, odd;

  always #2 clk = ~clk;

  yuv_timing_gen #(
    .LINE_60(L60), .LINE_50(L50), .ACT_60(A60), .ACT_50(A50),
    .LINES_60(F60), .LINES_50(F50), .HREF_START(HST),
    .HS_WIDTH(HSW), .VS_LINES(VSL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_50_i(mode_50), .fmt_411_i(fmt_411),
    .hs_pos_i(hs_pos), .fast_en_i(fast_en), .mux_force_i(mux_force),
    .y_i(y_in), .u_i(u_in), .v_i(v_in),
    .y_o(y_out), .uv_o(uv_out), .bus_oe_o(oe),
    .href_o(href), .hs_o(hs), .vs_o(vs), .odd_o(odd)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, p = 0, last_rise = -1;
  logic href_prev = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // reference frame position, same reset and edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) p <= 0;
    else p <= (p + 1) % ((mode_50 ? L50 : L60) * (mode_50 ? F50 : F60));
  end

  always @(negedge clk) begin
    int ll, al, fl, half, s, ofs, k;
    bit e_href, e_hs, e_vs, e_odd, e_oe;
    int e_y, e_uv;
    cyc++;
    ll = mode_50 ? L50 : L60;
    al = mode_50 ? A50 : A60;
    fl = mode_50 ? F50 : F60;
    half = ll * fl / 2;
    s = p % ll;
    e_href = (s >= HST) && (s < HST + al);
    e_hs = (s >= int'(hs_pos)) && (s < int'(hs_pos) + HSW);
    e_vs = (p < VSL * ll) || (p >= half && p < half + VSL * ll);
    e_odd = p < half;
    e_oe = !fast_en || (mux_force != 0);
    ofs = s - HST;
    k = ofs % 4;
    if (!e_href) begin e_y = 8'h10; e_uv = 8'h80; end
    else begin
      e_y = y_in;
      if (fmt_411)
        e_uv = (((u_in >> (6 - 2 * k)) & 3) << 6) | (((v_in >> (6 - 2 * k)) & 3) << 4);
      else e_uv = (ofs % 2 == 0) ? u_in : v_in;
    end
    if (!rst_n) begin
      chk(!href && vs && odd, "R11", "reset state", {href, vs, odd}, 3'b011);
      last_rise = -1;
    end else begin
      chk(href == e_href, e_vs ? "R3" : "R2", "href", href, e_href);
      chk(hs == e_hs, "R6", "hs", hs, e_hs);
      chk(vs == e_vs, "R5", "vs", vs, e_vs);
      chk(odd == e_odd, "R4", "odd", odd, e_odd);
      chk(y_out == e_y[7:0], e_href ? "R9" : "R9", "y", y_out, e_y);
      chk(uv_out == e_uv[7:0], !e_href ? "R9" : (fmt_411 ? "R8" : "R7"), "uv", uv_out, e_uv);
      if (href && !href_prev) begin
        if (last_rise >= 0) chk(cyc - last_rise == ll, "R1", "line period", cyc - last_rise, ll);
        last_rise = cyc;
      end
    end
    chk(oe == e_oe, "R10", "bus_oe", oe, e_oe);
    href_prev = href;
  end

  task automatic run(input int n, input bit toggle_en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      y_in = 8'($urandom); u_in = 8'($urandom); v_in = 8'($urandom);
      if (toggle_en) begin
        fast_en = 1'($urandom);
        mux_force = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
      end
    end
  endtask

  task automatic restart(input bit m50, input bit f411, input int hp);
    @(negedge clk); #1;
    rst_n = 0; mode_50 = m50; fmt_411 = f411; hs_pos = SW'(hp);
    fast_en = 0; mux_force = '0;
    run(3, 0);
    @(negedge clk); #1;
    rst_n = 1;
  endtask

  initial begin
    run(4, 0);
    rst_n = 1;
    run(2 * L60 * F60 + 10, 0);
    restart(0, 1, 0);
    run(2 * L60 * F60, 1);
    restart(1, 1, L50 - 2);
    run(3 * L50 * F50, 1);
    restart(1, 0, 9);
    run(2 * L50 * F50, 1);
    // each enable combination held explicitly
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); #1;
      fast_en = c[0]; mux_force = c[3:1];
    end
    run(4, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: got timeout expected end", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule